// File: doc/BRIEF.md
# Transmit Mailbox Status Tracker

This block holds the status of three transmit mailboxes that sit in front of a CAN protocol engine. Software posts a frame by pulsing a per-mailbox request strobe. From then on the mailbox counts as pending until the engine reports a result for it, or until an abort removes it. The block presents one packed 32-bit status word. It shows which mailboxes are free and which pending mailbox would go out last. It also gives a two-bit code that names a free mailbox, or names the mailbox to displace when all three are busy.

Each mailbox also keeps four sticky result flags: completed, succeeded, lost arbitration and bus error. Software clears them by writing ones through a plain write port. An abort bit per mailbox can be set by software but only hardware clears it. An abort cancels a pending mailbox at once when the engine is not transmitting it. Otherwise the abort waits for the engine's result. Priority keys come in live from the mailbox identifiers, and a lower key wins the bus.

Top module: `txmb_status_tracker`

## Requirements
- R1: While reset is asserted, and right after it, the status word reads 0x1C000000.
- R2: The empty flag of mailbox i is at bit 26+i. It reads 0 from the cycle after the request strobe for i and reads 1 again after a result event or a completed abort for i.
- R3: With two or more mailboxes pending, exactly one lowest-priority flag is set, at bit 29+i. It belongs to the pending mailbox with the largest key. Among equal keys it goes to the higher index.
- R4: With zero or one mailbox pending, bits 31:29 read 0.
- R5: Bits 25:24 give the lowest index of an empty mailbox. When no mailbox is empty they give the index of the lowest-priority mailbox.
- R6: Mailbox i uses the field at bits 8i+3..8i: bit 0 is completed, bit 1 is success, bit 2 is arbitration lost and bit 3 is error. A result event for i sets completed, loads success from the outcome, sets the lost and error flags when reported, and clears pending.
- R7: A write with bit 8i+k set (k=0..3) clears that flag, and a 0 bit leaves it unchanged. A hardware set in the same cycle wins over the clear.
- R8: Writing 1 to bit 8i+7 sets the abort bit, and writing 0 does not clear it. For a pending mailbox that is not busy, the next cycle clears pending and the abort bit, sets completed and clears success.
- R9: The abort bit of a busy mailbox stays set, and the mailbox stays pending, until the result event for it. That event clears the abort bit and records its outcome.
- R10: The abort bit of an idle mailbox clears one cycle after it is set and leaves the result flags unchanged.
- R11: Bits 8i+6..8i+4 read 0, and writing them has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_set_i | input | 3 | Per-mailbox transmit request strobe |
| key_i | input | 3*KEY_W | Priority keys, mailbox i at bits i*KEY_W upward; lower key wins |
| busy_i | input | 3 | Mailbox currently being transmitted by the engine |
| wr_en_i | input | 1 | Status word write strobe |
| wr_data_i | input | 32 | Write data: clear flags with 1s, set abort bits with 1s |
| res_valid_i | input | 1 | Result event strobe from the engine |
| res_mb_i | input | 2 | Mailbox index of the result event |
| res_ok_i | input | 1 | Result: transmission succeeded |
| res_alst_i | input | 1 | Result: arbitration lost |
| res_terr_i | input | 1 | Result: transmit error |
| status_o | output | 32 | Packed status word |

## Verification
Ordering among pending mailboxes covers a large space. The bench walks every pending pattern against every key triple drawn from three values, which includes all the tie cases. Before each combination, an abort on all three mailboxes followed by a clear-all write returns the block to an idle state that is known from its ports alone. The hardest state to reach is an abort against a mailbox the engine is sending. The bench holds the busy input while the abort is written, then confirms that the abort survives a zero write and that it resolves only on the result event.

// File: rtl/txmb_pkg.sv
`timescale 1ns/1ps
package txmb_pkg;
  localparam int NUM_MB     = 3;
  localparam int IDX_W      = 2;
  localparam int FIELD_W    = 8;
  localparam int FLAG_W     = 4;
  localparam int ABORT_OFS  = 7;
  localparam int CODE_LSB   = 24;
  localparam int EMPTY_BASE = 26;
  localparam int LOW_BASE   = 29;
  localparam int STATUS_W   = 32;

  typedef struct packed {
    logic terr;
    logic alst;
    logic txok;
    logic rqcp;
  } mb_flags_t;
endpackage

// File: rtl/txmb_slot.sv
`timescale 1ns/1ps
module txmb_slot
  import txmb_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_set_i,
  input  logic                busy_i,
  input  logic                abort_wr_i,
  input  logic [FLAG_W-1:0]   clr_i,
  input  logic                res_hit_i,
  input  logic                res_ok_i,
  input  logic                res_alst_i,
  input  logic                res_terr_i,
  output logic                pend_o,
  output logic                abrq_o,
  output mb_flags_t           flags_o
);
  logic      pend_q, pend_d;
  logic      abrq_q, abrq_d;
  mb_flags_t flags_q, flags_d;
  logic      abort_fire;
  logic      ce;

  always_comb begin
    abort_fire = abrq_q & ~busy_i;
    ce = req_set_i | abort_wr_i | abrq_q | res_hit_i | (|clr_i);
    pend_d  = pend_q;
    abrq_d  = abrq_q;
    flags_d = mb_flags_t'(flags_q & ~clr_i);
    if (abort_fire) begin
      abrq_d = 1'b0;
      if (pend_q) begin
        pend_d       = 1'b0;
        flags_d.rqcp = 1'b1;
        flags_d.txok = 1'b0;
      end
    end
    if (res_hit_i) begin
      pend_d       = 1'b0;
      abrq_d       = 1'b0;
      flags_d.rqcp = 1'b1;
      flags_d.txok = res_ok_i;
      if (res_alst_i) flags_d.alst = 1'b1;
      if (res_terr_i) flags_d.terr = 1'b1;
    end
    if (abort_wr_i) abrq_d = 1'b1;
    if (req_set_i)  pend_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q  <= 1'b0;
      abrq_q  <= 1'b0;
      flags_q <= '0;
    end else if (ce) begin
      pend_q  <= pend_d;
      abrq_q  <= abrq_d;
      flags_q <= flags_d;
    end
  end

  assign pend_o  = pend_q;
  assign abrq_o  = abrq_q;
  assign flags_o = flags_q;
endmodule

// File: rtl/txmb_rank.sv
`timescale 1ns/1ps
module txmb_rank #(
  parameter int NUM_MB = 3,
  parameter int KEY_W  = 11,
  parameter int IDX_W  = 2
) (
  input  logic [NUM_MB-1:0]       pend_i,
  input  logic [NUM_MB*KEY_W-1:0] keys_i,
  output logic [NUM_MB-1:0]       low_o,
  output logic [IDX_W-1:0]        code_o
);
  localparam int CMP_W = KEY_W + IDX_W;

  logic [CMP_W-1:0] loser_val;
  logic [CMP_W-1:0] cand;
  logic [IDX_W-1:0] loser_idx;
  logic             found;
  int               cnt;

  always_comb begin
    cnt       = 0;
    found     = 1'b0;
    loser_val = '0;
    loser_idx = '0;
    cand      = '0;
    for (int i = 0; i < NUM_MB; i++) begin
      cand = {keys_i[i*KEY_W +: KEY_W], IDX_W'(i)};
      if (pend_i[i]) begin
        cnt = cnt + 1;
        if (!found || cand > loser_val) begin
          loser_val = cand;
          loser_idx = IDX_W'(i);
          found     = 1'b1;
        end
      end
    end
  end

  always_comb begin
    for (int i = 0; i < NUM_MB; i++)
      low_o[i] = (cnt >= 2) && (loser_idx == IDX_W'(i));
  end

  always_comb begin
    code_o = loser_idx;
    for (int i = NUM_MB - 1; i >= 0; i--)
      if (!pend_i[i]) code_o = IDX_W'(i);
  end
endmodule

// File: rtl/txmb_status_tracker.sv
`timescale 1ns/1ps
module txmb_status_tracker
  import txmb_pkg::*;
#(
  parameter int KEY_W = 11
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [2:0]              req_set_i,
  input  logic [3*KEY_W-1:0]      key_i,
  input  logic [2:0]              busy_i,
  input  logic                    wr_en_i,
  input  logic [31:0]             wr_data_i,
  input  logic                    res_valid_i,
  input  logic [1:0]              res_mb_i,
  input  logic                    res_ok_i,
  input  logic                    res_alst_i,
  input  logic                    res_terr_i,
  output logic [31:0]             status_o
);
  logic [NUM_MB-1:0] pend;
  logic [NUM_MB-1:0] abrq;
  logic [NUM_MB-1:0] low;
  logic [IDX_W-1:0]  code;
  mb_flags_t         flags [NUM_MB];

  for (genvar i = 0; i < NUM_MB; i++) begin : g_slot
    logic             res_hit;
    logic             abort_wr;
    logic [FLAG_W-1:0] clr;

    assign res_hit  = res_valid_i && (res_mb_i == IDX_W'(i));
    assign abort_wr = wr_en_i && wr_data_i[i*FIELD_W + ABORT_OFS];
    assign clr      = wr_en_i ? wr_data_i[i*FIELD_W +: FLAG_W] : '0;

    txmb_slot u_slot (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .req_set_i  (req_set_i[i]),
      .busy_i     (busy_i[i]),
      .abort_wr_i (abort_wr),
      .clr_i      (clr),
      .res_hit_i  (res_hit),
      .res_ok_i   (res_ok_i),
      .res_alst_i (res_alst_i),
      .res_terr_i (res_terr_i),
      .pend_o     (pend[i]),
      .abrq_o     (abrq[i]),
      .flags_o    (flags[i])
    );
  end

  txmb_rank #(
    .NUM_MB (NUM_MB),
    .KEY_W  (KEY_W),
    .IDX_W  (IDX_W)
  ) u_rank (
    .pend_i (pend),
    .keys_i (key_i),
    .low_o  (low),
    .code_o (code)
  );

  always_comb begin
    status_o = '0;
    for (int i = 0; i < NUM_MB; i++) begin
      status_o[i*FIELD_W +: FLAG_W]       = flags[i];
      status_o[i*FIELD_W + ABORT_OFS]     = abrq[i];
      status_o[EMPTY_BASE + i]            = ~pend[i];
      status_o[LOW_BASE + i]              = low[i];
    end
    status_o[CODE_LSB +: IDX_W] = code;
  end
endmodule

// File: rtl/txmb_status_checker.sv
`timescale 1ns/1ps
module txmb_status_checker
  import txmb_pkg::*;
(
  input logic        clk_i,
  input logic        rst_ni,
  input logic [2:0]  req_set_i,
  input logic [2:0]  busy_i,
  input logic        wr_en_i,
  input logic [31:0] wr_data_i,
  input logic        res_valid_i,
  input logic [1:0]  res_mb_i,
  input logic        res_ok_i,
  input logic [31:0] status_o
);
  logic [2:0] empty_v;
  logic [2:0] low_v;
  assign empty_v = status_o[EMPTY_BASE +: 3];
  assign low_v   = status_o[LOW_BASE +: 3];

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      assert_reset_word_R1: assert (status_o == 32'h1C00_0000)
        else $error("status word not at reset value");
    end
  end

  assert_low_onehot_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(low_v));

  assert_low_only_pending_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (low_v & empty_v) == 3'b000);

  assert_low_needs_two_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($countones(empty_v) >= 2) |-> (low_v == 3'b000));

  for (genvar i = 0; i < 3; i++) begin : g_mb
    assert_req_pends_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      req_set_i[i] |=> !status_o[EMPTY_BASE + i]);

    assert_ok_result_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (res_valid_i && res_mb_i == 2'(i) && res_ok_i && !req_set_i[i])
      |=> (status_o[i*FIELD_W] && status_o[i*FIELD_W + 1] && status_o[EMPTY_BASE + i]));

    assert_w1c_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && wr_data_i[i*FIELD_W] && !(res_valid_i && res_mb_i == 2'(i))
       && !status_o[i*FIELD_W + ABORT_OFS])
      |=> !status_o[i*FIELD_W]);

    assert_abort_cancel_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (status_o[i*FIELD_W + ABORT_OFS] && !busy_i[i] && !status_o[EMPTY_BASE + i]
       && !req_set_i[i] && !(res_valid_i && res_mb_i == 2'(i))
       && !(wr_en_i && wr_data_i[i*FIELD_W + ABORT_OFS]))
      |=> (status_o[EMPTY_BASE + i] && status_o[i*FIELD_W] && !status_o[i*FIELD_W + 1]
           && !status_o[i*FIELD_W + ABORT_OFS]));

    assert_abort_waits_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (status_o[i*FIELD_W + ABORT_OFS] && busy_i[i] && !(res_valid_i && res_mb_i == 2'(i)))
      |=> status_o[i*FIELD_W + ABORT_OFS]);
  end
endmodule

bind txmb_status_tracker txmb_status_checker u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_set_i   (req_set_i),
  .busy_i      (busy_i),
  .wr_en_i     (wr_en_i),
  .wr_data_i   (wr_data_i),
  .res_valid_i (res_valid_i),
  .res_mb_i    (res_mb_i),
  .res_ok_i    (res_ok_i),
  .status_o    (status_o)
);

// File: tb/txmb_status_tracker_tb.sv
`timescale 1ns/1ps
module txmb_status_tracker_tb;
  localparam int KEY_W = 11;

  logic              clk;
  logic              rst_ni;
  logic [2:0]        req_set;
  logic [3*KEY_W-1:0] keys;
  logic [2:0]        busy;
  logic              wr_en;
  logic [31:0]       wr_data;
  logic              res_valid;
  logic [1:0]        res_mb;
  logic              res_ok, res_alst, res_terr;
  logic [31:0]       status;

  int checks = 0;
  int failures = 0;

  txmb_status_tracker #(.KEY_W(KEY_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .req_set_i(req_set), .key_i(keys),
    .busy_i(busy), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .res_valid_i(res_valid), .res_mb_i(res_mb), .res_ok_i(res_ok),
    .res_alst_i(res_alst), .res_terr_i(res_terr), .status_o(status)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic step();
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] d);
    wr_en = 1'b1; wr_data = d; step(); wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic post(input logic [2:0] p);
    req_set = p; step(); req_set = '0;
  endtask

  task automatic result(input int mb, input logic ok, input logic al, input logic te);
    res_valid = 1'b1; res_mb = 2'(mb); res_ok = ok; res_alst = al; res_terr = te;
    step();
    res_valid = 1'b0; res_ok = 1'b0; res_alst = 1'b0; res_terr = 1'b0;
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(200000 * 20);
    checks++; failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] snap;
    rst_ni = 1'b1; req_set = '0; keys = '0; busy = '0; wr_en = 1'b0; wr_data = '0;
    res_valid = 1'b0; res_mb = '0; res_ok = 1'b0; res_alst = 1'b0; res_terr = 1'b0;
    #2 rst_ni = 1'b0;
    step(); step();
    chk("R1 in reset", status, 32'h1C00_0000);
    rst_ni = 1'b1;
    step();
    chk("R1 after reset", status, 32'h1C00_0000);

    // Sweep every pending pattern against every key triple from {0,1,2}
    for (int p = 0; p < 8; p++) begin
      for (int t = 0; t < 27; t++) begin
        int k [3];
        int rank, maxv, maxi, cnt;
        logic [2:0] pat, explow;
        logic [1:0] expcode;
        pat = 3'(p);
        k[0] = t % 3; k[1] = (t / 3) % 3; k[2] = t / 9;
        wr(32'h0080_8080);
        step();
        wr(32'h000F_0F0F);
        keys = {KEY_W'(k[2]), KEY_W'(k[1]), KEY_W'(k[0])};
        post(pat);
        maxv = -1; maxi = 0; cnt = 0;
        for (int i = 0; i < 3; i++) begin
          rank = k[i] * 4 + i;
          if (pat[i]) begin
            cnt++;
            if (rank > maxv) begin maxv = rank; maxi = i; end
          end
        end
        explow = (cnt >= 2) ? 3'(1 << maxi) : 3'b000;
        expcode = 2'(maxi);
        for (int i = 2; i >= 0; i--) if (!pat[i]) expcode = 2'(i);
        chk("R2 empty flags", {29'd0, status[28:26]}, {29'd0, ~pat});
        if (cnt >= 2) chk("R3 lowest flag", {29'd0, status[31:29]}, {29'd0, explow});
        else          chk("R4 lowest flag", {29'd0, status[31:29]}, {29'd0, explow});
        chk("R5 code", {30'd0, status[25:24]}, {30'd0, expcode});
      end
    end

    wr(32'h0080_8080); step(); wr(32'h000F_0F0F);
    chk("R2 all idle", status & 32'h1C00_0000, 32'h1C00_0000);

    // Result events on mailbox 1
    post(3'b010);
    result(1, 1'b1, 1'b0, 1'b0);
    chk("R6 ok result", {28'd0, status[11:8]}, 32'h3);
    chk("R2 empty after result", {31'd0, status[27]}, 32'h1);
    post(3'b010);
    result(1, 1'b0, 1'b1, 1'b0);
    chk("R6 lost result", {28'd0, status[11:8]}, 32'h5);
    wr(32'h0000_0100);
    chk("R7 clear completed only", {28'd0, status[11:8]}, 32'h4);

    // Error on mailbox 2, then clear colliding with hardware set
    post(3'b100);
    result(2, 1'b0, 1'b0, 1'b1);
    chk("R6 error result", {28'd0, status[19:16]}, 32'h9);
    res_valid = 1'b1; res_mb = 2'd2; res_terr = 1'b1;
    wr_en = 1'b1; wr_data = 32'h0008_0000;
    step();
    res_valid = 1'b0; res_terr = 1'b0; wr_en = 1'b0; wr_data = '0;
    chk("R7 hardware set wins", {31'd0, status[19]}, 32'h1);
    wr(32'h0008_0000);
    chk("R7 error cleared", {28'd0, status[19:16]}, 32'h1);

    // Abort of a pending, idle-engine mailbox 0
    post(3'b001);
    result(0, 1'b1, 1'b0, 1'b0);
    wr(32'h0000_0001);
    chk("R7 success kept", {28'd0, status[3:0]}, 32'h2);
    post(3'b001);
    chk("R2 pending mb0", {31'd0, status[26]}, 32'h0);
    wr(32'h0000_0080);
    chk("R8 abort set", {31'd0, status[7]}, 32'h1);
    step();
    chk("R8 abort flags", {28'd0, status[3:0]}, 32'h1);
    chk("R8 abort cleared", {31'd0, status[7]}, 32'h0);
    chk("R8 mailbox empty", {31'd0, status[26]}, 32'h1);

    // Abort of a busy mailbox 1
    wr(32'h0000_0F00);
    busy = 3'b010;
    post(3'b010);
    wr(32'h0000_8000);
    step(); step();
    chk("R9 abort held", {31'd0, status[15]}, 32'h1);
    chk("R9 still pending", {31'd0, status[27]}, 32'h0);
    wr(32'h0000_0000);
    chk("R8 zero write keeps abort", {31'd0, status[15]}, 32'h1);
    result(1, 1'b1, 1'b0, 1'b0);
    chk("R9 abort released", {31'd0, status[15]}, 32'h0);
    chk("R9 empty after result", {31'd0, status[27]}, 32'h1);
    chk("R9 outcome recorded", {28'd0, status[11:8]}, 32'h3);
    busy = 3'b000;

    // Abort of an idle mailbox 2
    wr(32'h000F_0000);
    wr(32'h0080_0000);
    chk("R10 abort visible", {31'd0, status[23]}, 32'h1);
    step();
    chk("R10 abort gone", {31'd0, status[23]}, 32'h0);
    chk("R10 flags untouched", {28'd0, status[19:16]}, 32'h0);

    // Reserved bits
    snap = status;
    wr(32'h0070_7070);
    chk("R11 write ignored", status, snap);
    chk("R11 reserved zero", status & 32'h0070_7070, 32'h0);

    finish_run();
  end
endmodule